// File: doc/BRIEF.md
# Mandelbrot Escape-Time Pixel Pipeline

This block turns a stream of screen coordinates into grey levels that draw the Mandelbrot set. Each clock it may take one pixel position together with a viewing window on the complex plane. The window is given as a real origin, a real span, an imaginary origin and an imaginary span. The pixel is mapped to a point c, and that point is pushed through a fixed chain of unrolled iteration stages. The number of iterations the point survives is then turned into an 8-bit brightness. Points that stay bounded come out black, and points that escape early come out bright.

All arithmetic is signed fixed point. Window values use DW bits with FRAC fractional bits (Q4.12 by default). The iterate z and its squares are carried on a wider internal word, so bounded orbits cannot wrap. A valid flag travels beside the data. Every accepted pixel appears at the output a fixed number of cycles later, whatever its escape count. Pixels therefore leave in the same order they entered, and a display pipeline can treat the block as a pure delay line.

Top module: `mbrot_pixel_pipe`

## Requirements
- R1: Each pixel maps to c_re = re_start + trunc((x * re_span) / FRAME_W) and c_im = im_start + trunc((y * im_span) / FRAME_H). Here x and y are unsigned, the window values are signed Q4.12, the division truncates toward zero, and each sum wraps to DW bits.
- R2: Every pixel starts from z = 0 with both squares at 0 and a count of 0. It passes through exactly ITER (default 14) iteration stages, so its final count lies between 1 and ITER.
- R3: A live stage passes its escape test when sq_re + sq_im is at most 4.0 (value 16384 in Q4.12). Equality still passes.
- R4: On a passing stage the updates happen in this order. First, im becomes ((re*im) >>> FRAC) << 1 plus c_im. Next, re becomes sq_re - sq_im + c_re. Then new squares are formed as (v*v) >>> FRAC from the updated re and im. Finally the count rises by one. The shifts are arithmetic.
- R5: Once a stage fails the test, the pixel is frozen. Every later stage keeps z, the squares and the count unchanged.
- R6: The output level is 255 - (count*255)/ITER, using integer division. This gives 0 for count ITER and 237 for count 1.
- R7: out_valid rises exactly ITER+2 cycles after the matching in_valid. Results leave in input order, and cycles with in_valid low produce no output.
- R8: The window inputs are captured together with each pixel. A window change between two adjacent pixels affects only the later pixel.
- R9: While rst_n is low, and afterwards until the first accepted pixel has crossed the pipeline, out_valid stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset of the valid chain |
| in_valid | input | 1 | Pixel present this cycle |
| in_x | input | XW | Pixel column |
| in_y | input | XW | Pixel row |
| win_re_start | input | DW | Real origin of the window, signed fixed point |
| win_re_span | input | DW | Real extent across FRAME_W columns |
| win_im_start | input | DW | Imaginary origin of the window |
| win_im_span | input | DW | Imaginary extent across FRAME_H rows |
| out_valid | output | 1 | Level present this cycle |
| out_level | output | LW | Grey level of the pixel |

## Verification
The bench builds the block with its default parameters: 16-bit Q4.12 windows, 12-bit coordinates, a 640 by 480 frame and 14 stages. This lets exact threshold points be placed with a degenerate window. A span of zero with an origin of exactly 2.0, or one step above it, lands on the equality edge of the escape test. With 14 stages, counts from 1 through the black interior level are reachable in a short sweep over the usual view. Back-to-back pixels with alternating windows, and gaps in the stream, exercise the per-pixel window capture and the fixed latency.

// File: rtl/mbrot_pkg.sv
package mbrot_pkg;

   // Grey level for an escape count: full scale minus a linear share.
   function automatic int unsigned grey_of(int unsigned cnt, int unsigned iters,
                                           int unsigned full);
      return full - (cnt * full) / iters;
   endfunction

endpackage

// File: rtl/mbrot_map.sv
// Pixel coordinate to point on the complex plane, one register stage.
module mbrot_map #(
   parameter int DW      = 16,
   parameter int XW      = 12,
   parameter int IW      = 22,
   parameter int FRAME_W = 640,
   parameter int FRAME_H = 480
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 v_i,
   input  logic [XW-1:0]        x_i,
   input  logic [XW-1:0]        y_i,
   input  logic signed [DW-1:0] re_s_i,
   input  logic signed [DW-1:0] re_w_i,
   input  logic signed [DW-1:0] im_s_i,
   input  logic signed [DW-1:0] im_h_i,
   output logic                 v_o,
   output logic signed [IW-1:0] cre_o,
   output logic signed [IW-1:0] cim_o
);
   localparam int PW = XW + 1 + DW;
   localparam logic signed [PW-1:0] FW_S = PW'(FRAME_W);
   localparam logic signed [PW-1:0] FH_S = PW'(FRAME_H);

   logic signed [PW-1:0] px, py, qx, qy;
   logic signed [DW-1:0] cre_d, cim_d;

   assign px = $signed({{DW{1'b0}}, x_i}) * $signed({{(XW+1){re_w_i[DW-1]}}, re_w_i});
   assign py = $signed({{DW{1'b0}}, y_i}) * $signed({{(XW+1){im_h_i[DW-1]}}, im_h_i});
   assign qx = px / FW_S;
   assign qy = py / FH_S;
   assign cre_d = re_s_i + qx[DW-1:0];
   assign cim_d = im_s_i + qy[DW-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) v_o <= 1'b0;
      else        v_o <= v_i;
      cre_o <= {{(IW-DW){cre_d[DW-1]}}, cre_d};
      cim_o <= {{(IW-DW){cim_d[DW-1]}}, cim_d};
   end

   AST_MAP_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      v_i |=> v_o); // R7
   AST_MAP_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      !v_i |=> !v_o); // R7

endmodule

// File: rtl/mbrot_iter.sv
// One unrolled escape iteration with a freeze flag, one register stage.
module mbrot_iter #(
   parameter int IW   = 22,
   parameter int FRAC = 12,
   parameter int CW   = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 v_i,
   input  logic                 alive_i,
   input  logic [CW-1:0]        cnt_i,
   input  logic signed [IW-1:0] cre_i,
   input  logic signed [IW-1:0] cim_i,
   input  logic signed [IW-1:0] zre_i,
   input  logic signed [IW-1:0] zim_i,
   input  logic signed [IW-1:0] sre_i,
   input  logic signed [IW-1:0] sim_i,
   output logic                 v_o,
   output logic                 alive_o,
   output logic [CW-1:0]        cnt_o,
   output logic signed [IW-1:0] cre_o,
   output logic signed [IW-1:0] cim_o,
   output logic signed [IW-1:0] zre_o,
   output logic signed [IW-1:0] zim_o,
   output logic signed [IW-1:0] sre_o,
   output logic signed [IW-1:0] sim_o
);
   localparam logic signed [IW:0] FOUR = (IW+1)'(4 << FRAC);

   logic signed [IW:0]     mag;
   logic                   pass;
   logic signed [2*IW-1:0] p_ri, s_ri, p_rr, s_rr, p_ii, s_ii;
   logic signed [IW-1:0]   half, nim, nre;

   assign mag  = sre_i + sim_i;
   assign pass = alive_i && (mag <= FOUR);

   // imaginary first, doubling by a left shift
   assign p_ri = zre_i * zim_i;
   assign s_ri = p_ri >>> FRAC;
   assign half = s_ri[IW-1:0];
   assign nim  = (half <<< 1) + cim_i;
   // real from the squares of the previous step
   assign nre  = sre_i - sim_i + cre_i;
   // squares from the fresh values
   assign p_rr = nre * nre;
   assign s_rr = p_rr >>> FRAC;
   assign p_ii = nim * nim;
   assign s_ii = p_ii >>> FRAC;

   always_ff @(posedge clk) begin
      if (!rst_n) v_o <= 1'b0;
      else        v_o <= v_i;
      cre_o   <= cre_i;
      cim_o   <= cim_i;
      alive_o <= pass;
      if (pass) begin
         zre_o <= nre;
         zim_o <= nim;
         sre_o <= s_rr[IW-1:0];
         sim_o <= s_ii[IW-1:0];
         cnt_o <= cnt_i + CW'(1);
      end else begin
         zre_o <= zre_i;
         zim_o <= zim_i;
         sre_o <= sre_i;
         sim_o <= sim_i;
         cnt_o <= cnt_i;
      end
   end

   AST_FROZEN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (v_i && !alive_i) |=> (!alive_o && cnt_o == $past(cnt_i)
                             && zre_o == $past(zre_i) && zim_o == $past(zim_i))); // R5
   AST_ESCAPE_KILLS: assert property (@(posedge clk) disable iff (!rst_n)
      (v_i && alive_i && (sre_i + sim_i > FOUR)) |=> !alive_o); // R3
   AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (v_i && alive_i) |=> (alive_o == (cnt_o == $past(cnt_i) + CW'(1)))); // R4
   AST_STAGE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      v_i |=> v_o); // R7

endmodule

// File: rtl/mbrot_shade.sv
// Escape count to grey level through a computed lookup, one register stage.
module mbrot_shade #(
   parameter int ITER = 14,
   parameter int CW   = 4,
   parameter int LW   = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          v_i,
   input  logic [CW-1:0] cnt_i,
   output logic          v_o,
   output logic [LW-1:0] level_o
);
   localparam int unsigned FULL = (1 << LW) - 1;

   logic [LW-1:0] lut [ITER+1];

   for (genvar g = 0; g <= ITER; g++) begin : g_lut
      assign lut[g] = LW'(mbrot_pkg::grey_of(g, ITER, FULL));
   end

   logic [LW-1:0] pick;
   assign pick = (cnt_i > CW'(ITER)) ? '0 : lut[cnt_i];

   always_ff @(posedge clk) begin
      if (!rst_n) v_o <= 1'b0;
      else        v_o <= v_i;
      level_o <= pick;
   end

   AST_DARK_WHEN_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      (v_i && cnt_i == CW'(ITER)) |=> (level_o == '0)); // R6
   AST_BRIGHT_AT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (v_i && cnt_i == CW'(1)) |=> (level_o == LW'(FULL - FULL / ITER))); // R6
   AST_SHADE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !v_i |=> !v_o); // R7

endmodule

// File: rtl/mbrot_pixel_pipe.sv
// Top: map, ITER unrolled iteration stages, shade. Latency ITER+2 cycles.
module mbrot_pixel_pipe #(
   parameter int DW      = 16,
   parameter int FRAC    = 12,
   parameter int GUARD   = 6,
   parameter int XW      = 12,
   parameter int FRAME_W = 640,
   parameter int FRAME_H = 480,
   parameter int ITER    = 14,
   parameter int LW      = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [XW-1:0] in_x,
   input  logic [XW-1:0] in_y,
   input  logic [DW-1:0] win_re_start,
   input  logic [DW-1:0] win_re_span,
   input  logic [DW-1:0] win_im_start,
   input  logic [DW-1:0] win_im_span,
   output logic          out_valid,
   output logic [LW-1:0] out_level
);
   localparam int IW      = DW + GUARD;
   localparam int CW      = $clog2(ITER + 1);
   localparam int LATENCY = ITER + 2;

   if (FRAC < 1 || FRAC >= DW) begin : g_bad_frac
      $error("FRAC must lie within the word");
   end
   if (GUARD < 5) begin : g_bad_guard
      $error("GUARD too small for bounded orbits");
   end
   if (ITER < 1 || LATENCY != ITER + 2) begin : g_bad_iter
      $error("ITER must be at least one");
   end
   if (FRAME_W < 1 || FRAME_H < 1 || FRAME_W >= (1 << XW) + 1) begin : g_bad_frame
      $error("frame size does not match coordinate width");
   end

   logic                 v_s   [ITER+1];
   logic                 al_s  [ITER+1];
   logic [CW-1:0]        cn_s  [ITER+1];
   logic signed [IW-1:0] cre_s [ITER+1];
   logic signed [IW-1:0] cim_s [ITER+1];
   logic signed [IW-1:0] zre_s [ITER+1];
   logic signed [IW-1:0] zim_s [ITER+1];
   logic signed [IW-1:0] sre_s [ITER+1];
   logic signed [IW-1:0] sim_s [ITER+1];

   mbrot_map #(.DW(DW), .XW(XW), .IW(IW), .FRAME_W(FRAME_W), .FRAME_H(FRAME_H)) u_map (
      .clk    (clk),
      .rst_n  (rst_n),
      .v_i    (in_valid),
      .x_i    (in_x),
      .y_i    (in_y),
      .re_s_i ($signed(win_re_start)),
      .re_w_i ($signed(win_re_span)),
      .im_s_i ($signed(win_im_start)),
      .im_h_i ($signed(win_im_span)),
      .v_o    (v_s[0]),
      .cre_o  (cre_s[0]),
      .cim_o  (cim_s[0])
   );

   assign al_s[0]  = 1'b1;
   assign cn_s[0]  = '0;
   assign zre_s[0] = '0;
   assign zim_s[0] = '0;
   assign sre_s[0] = '0;
   assign sim_s[0] = '0;

   for (genvar k = 0; k < ITER; k++) begin : g_stage
      mbrot_iter #(.IW(IW), .FRAC(FRAC), .CW(CW)) u_it (
         .clk     (clk),
         .rst_n   (rst_n),
         .v_i     (v_s[k]),
         .alive_i (al_s[k]),
         .cnt_i   (cn_s[k]),
         .cre_i   (cre_s[k]),
         .cim_i   (cim_s[k]),
         .zre_i   (zre_s[k]),
         .zim_i   (zim_s[k]),
         .sre_i   (sre_s[k]),
         .sim_i   (sim_s[k]),
         .v_o     (v_s[k+1]),
         .alive_o (al_s[k+1]),
         .cnt_o   (cn_s[k+1]),
         .cre_o   (cre_s[k+1]),
         .cim_o   (cim_s[k+1]),
         .zre_o   (zre_s[k+1]),
         .zim_o   (zim_s[k+1]),
         .sre_o   (sre_s[k+1]),
         .sim_o   (sim_s[k+1])
      );
   end

   mbrot_shade #(.ITER(ITER), .CW(CW), .LW(LW)) u_shade (
      .clk     (clk),
      .rst_n   (rst_n),
      .v_i     (v_s[ITER]),
      .cnt_i   (cn_s[ITER]),
      .v_o     (out_valid),
      .level_o (out_level)
   );

   AST_COUNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      v_s[ITER] |-> (cn_s[ITER] >= CW'(1) && cn_s[ITER] <= CW'(ITER))); // R2
   AST_FIRST_ALWAYS_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
      v_s[1] |-> (al_s[1] && cn_s[1] == CW'(1))); // R2

endmodule

// File: tb/sim_mbrot_pixel_pipe.sv
`timescale 1ns/1ps
module sim_mbrot_pixel_pipe;
   localparam int ITER = 14;
   localparam int LAT  = ITER + 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [11:0] in_x = '0, in_y = '0;
   logic [15:0] w_rs = '0, w_rw = '0, w_is = '0, w_ih = '0;
   logic        out_valid;
   logic [7:0]  out_level;

   int checks = 0, failures = 0;
   longint cyc = 0;
   int    exp_q[$];
   longint t_q[$];
   string tag_q[$];

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   mbrot_pixel_pipe u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
      .win_re_start(w_rs), .win_re_span(w_rw), .win_im_start(w_is), .win_im_span(w_ih),
      .out_valid(out_valid), .out_level(out_level)
   );

   function automatic longint wrap16(longint v);
      longint r;
      r = v & 64'hFFFF;
      if (r >= 32768) r = r - 65536;
      return r;
   endfunction

   // Reference from the requirements (R1..R6)
   function automatic int model(int x, int y, int rs, int rw, int is, int ih);
      longint cr, ci, zr, zi, sr, si, t;
      int cnt;
      bit alive;
      cr = wrap16(longint'(rs) + (longint'(x) * longint'(rw)) / 640);
      ci = wrap16(longint'(is) + (longint'(y) * longint'(ih)) / 480);
      zr = 0; zi = 0; sr = 0; si = 0; cnt = 0; alive = 1'b1;
      for (int k = 0; k < ITER; k++) begin
         if (alive && (sr + si <= 16384)) begin
            t  = (zr * zi) >>> 12;
            zi = (t <<< 1) + ci;
            zr = sr - si + cr;
            sr = (zr * zr) >>> 12;
            si = (zi * zi) >>> 12;
            cnt++;
         end else alive = 1'b0;
      end
      return 255 - (cnt * 255) / ITER;
   endfunction

   task automatic check(bit ok, string req, string what, longint act, longint expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   task automatic drive_px(int x, int y, int rs, int rw, int is, int ih, string tag);
      @(negedge clk);
      in_valid = 1'b1;
      in_x = 12'(x); in_y = 12'(y);
      w_rs = 16'(rs); w_rw = 16'(rw); w_is = 16'(is); w_ih = 16'(ih);
      exp_q.push_back(model(x, y, rs, rw, is, ih));
      t_q.push_back(cyc);
      tag_q.push_back(tag);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
         in_x = 12'hABC; w_rs = 16'h1234;
      end
   endtask

   // Monitor: pop and compare
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R7", "unexpected output", 1, 0);
         end else begin
            int e;
            longint t;
            string g;
            e = exp_q.pop_front();
            t = t_q.pop_front();
            g = tag_q.pop_front();
            check(out_level == 8'(e), g, "level", out_level, e);
            check(cyc - t == LAT, "R7", "latency", cyc - t, LAT);
         end
      end
   end

   initial begin
      fork
         begin
            // R9 reset state
            repeat (3) @(negedge clk);
            check(out_valid == 1'b0, "R9", "valid in reset", out_valid, 0);
            rst_n = 1'b1;
            repeat (3) @(negedge clk);
            check(out_valid == 1'b0, "R9", "valid after reset", out_valid, 0);
            // R3 boundary: exactly 4.0 passes, one step above fails
            drive_px(0, 0, 8192, 0, 0, 0, "R3");
            drive_px(0, 0, 8193, 0, 0, 0, "R3");
            drive_px(0, 0, 0, 0, 8192, 0, "R3");
            // R6 dark interior and bright far point
            drive_px(0, 0, 0, 0, 0, 0, "R6");
            drive_px(0, 0, 28000, 0, 0, 0, "R6");
            idle(3);
            // R1 R4 R5 sweep over the usual view
            for (int yy = 0; yy < 9; yy++)
               for (int xx = 0; xx < 9; xx++)
                  drive_px((xx == 8) ? 639 : xx * 80, (yy == 8) ? 479 : yy * 60,
                           -10240, 14336, -5120, 10240, "R1 R4 R5");
            // R8 window alternates per pixel
            for (int i = 0; i < 12; i++) begin
               if (i % 2 == 0) drive_px(320, 240, -10240, 14336, -5120, 10240, "R8");
               else            drive_px(320, 240, -3000, 2000, 2400, 1200, "R8");
            end
            // R7 gaps in the stream
            for (int i = 0; i < 6; i++) begin
               drive_px(100 + i * 70, 200, -8192, 12288, -4096, 8192, "R7");
               idle(i % 3);
            end
            idle(LAT + 6);
            check(exp_q.size() == 0, "R7", "pending results", exp_q.size(), 0);
         end
         begin
            repeat (100000) @(posedge clk);
            check(1'b0, "R7", "watchdog", 1, 0);
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule